// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block is a performance-monitoring unit. It holds a bank of sixteen 48-bit event counters. Each counter watches one line of an incoming vector of single-cycle event pulses. Software chooses that line by writing an 8-bit event code into a packed select register.

Counting is gated at two levels: a run bit shared by all counters and an enable bit for each counter. When a counter wraps past its maximum, it sets a sticky overflow bit. An interrupt line is raised while any overflow bit is set and not masked. Software clears overflow bits one at a time by writing ones to a clear register.

All configuration and counter state is reached through a simple memory-mapped port. The port takes 32-bit accesses, and 64-bit accesses for the counter slots. The block contains the register decode, the counters and their event multiplexers, the overflow status, the interrupt masking and the clear logic.

Top module: `evt_cnt_bank`

## Requirements
- R1: After reset every counter reads zero, the run bit (0x1E00 bit 0) and the enable register (0x1E04) read zero, the mask register (0x0804) reads all ones in its low 16 bits, status (0x0808) reads zero, every select register reads 0xFFFFFFFF and the interrupt output is low.
- R2: A counter increments by exactly one in each cycle in which all of the following hold: the run bit is 1, its own enable bit n is 1, its event code is not 0xFF, and the event input chosen by the code is high.
- R3: Code 0xFF, or a code at or above the number of event inputs (64 by default), selects no event, and such a counter never changes except by a software write.
- R4: While the run bit is 0, no counter advances, whatever the event inputs and enables are.
- R5: A counter whose enable bit is 0 holds its value while other counters keep counting.
- R6: The code for counter n sits in the select register at 0x1E80 + 4*(n/4), bits 8*(n%4)+7 down to 8*(n%4). A 32-bit write to a select register replaces all four codes in it.
- R7: Counter n occupies the 64-bit slot at 0x1F00 + 8*n. A 64-bit write loads bits 47:0. A 32-bit write at the slot offset loads bits 31:0, and a 32-bit write at offset +4 loads bits 47:32 from data bits 15:0. Slot bits 63:48 ignore writes and read as zero. A software write takes precedence over an increment in the same cycle.
- R8: When an increment takes a counter from 2^48-1 it becomes 0 and status bit n is set.
- R9: Writing 1 to bit n of the clear register (0x080C) clears status bit n, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear of that bit leaves the bit set.
- R10: The interrupt output is high exactly when some status bit n is 1 and mask bit n is 0. A mask bit of 1 suppresses that counter's interrupt.
- R11: The identifier register at 0x1CF0 returns the VERSION_ID parameter, and a read of any unmapped offset returns zero.
- R12: Read data appears on the read-data output one cycle after the read request and holds until the next read, even across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid_i | input | 1 | Access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_wide_i | input | 1 | 1 = 64-bit access (counter slots), 0 = 32-bit |
| bus_addr_i | input | 16 | Byte offset of the access |
| bus_wdata_i | input | 64 | Write data (bits 31:0 for 32-bit accesses) |
| bus_rdata_o | output | 64 | Registered read data |
| evt_i | input | EVT_NUM | Event pulse inputs, one per event code |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The embedded properties watch several rules on every clock cycle:
- a counter never moves by more than one step;
- it stays frozen while it is gated off or has no event selected;
- a wrap always lands on zero and sets its status bit, even against a clear;
- status bits never drop without a clear write;
- a fully masked bank keeps the interrupt low;
- read data is stable between reads.

Only the directed scenarios show the other behaviours:
- the exact count values;
- which byte lane of which select register steers which counter;
- the split of 32-bit and 64-bit preloads;
- the write-zero-does-nothing clear;
- the identifier and unmapped reads.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

    // Register offsets (byte addresses); software depends on these.
    localparam logic [15:0] OFS_MASK   = 16'h0804;
    localparam logic [15:0] OFS_STATUS = 16'h0808;
    localparam logic [15:0] OFS_CLEAR  = 16'h080C;
    localparam logic [15:0] OFS_IDENT  = 16'h1CF0;
    localparam logic [15:0] OFS_RUN    = 16'h1E00;
    localparam logic [15:0] OFS_ENABLE = 16'h1E04;
    localparam logic [15:0] OFS_SELECT = 16'h1E80;
    localparam logic [15:0] OFS_SLOT   = 16'h1F00;

    localparam int          CODE_W     = 8;
    localparam logic [7:0]  CODE_NONE  = 8'hFF;
    localparam int          CODES_PER_SEL = 4;

endpackage

// File: rtl/evt_cnt_lane.sv
module evt_cnt_lane
    import evt_cnt_pkg::*;
#(
    parameter int CNT_W   = 48,
    parameter int EVT_NUM = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic [CODE_W-1:0]   code_i,
    input  logic [EVT_NUM-1:0]  evt_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [31:0]         lo_val_i,
    input  logic [CNT_W-33:0]   hi_val_i,
    output logic [CNT_W-1:0]    cnt_o,
    output logic                wrap_o
);

    localparam int IDX_W = (EVT_NUM > 1) ? $clog2(EVT_NUM) : 1;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             hit;
    logic             sw_wr;

    always_comb begin
        sw_wr = wr_lo_i || wr_hi_i;
        hit   = 1'b0;
        if (run_i && (code_i != CODE_NONE) && (int'(code_i) < EVT_NUM))
            hit = evt_i[code_i[IDX_W-1:0]];

        wrap_o = hit && !sw_wr && (cnt_q == '1);

        cnt_d = cnt_q;
        if (sw_wr) begin
            if (wr_lo_i) cnt_d[31:0]       = lo_val_i;
            if (wr_hi_i) cnt_d[CNT_W-1:32] = hi_val_i;
        end else if (hit) begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0)); // R8
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + ONE))); // R2
    AST_NO_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_i == CODE_NONE) && !sw_wr) |=> $stable(cnt_q)); // R3
    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !sw_wr) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/evt_cnt_rdmux.sv
module evt_cnt_rdmux
    import evt_cnt_pkg::*;
#(
    parameter int          NUM_CNT    = 16,
    parameter int          CNT_W      = 48,
    parameter logic [31:0] VERSION_ID = 32'h5A17_0300
) (
    input  logic [15:0]                     addr_i,
    input  logic                            wide_i,
    input  logic                            run_i,
    input  logic [NUM_CNT-1:0]              ena_i,
    input  logic [NUM_CNT-1:0]              mask_i,
    input  logic [NUM_CNT-1:0]              status_i,
    input  logic [NUM_CNT-1:0][CODE_W-1:0]  codes_i,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_i,
    output logic [63:0]                     data_o
);

    localparam int NUM_SEL = NUM_CNT / CODES_PER_SEL;
    localparam int HI_W    = CNT_W - 32;

    always_comb begin
        data_o = '0;
        if (addr_i == OFS_RUN)    data_o[0]           = run_i;
        if (addr_i == OFS_ENABLE) data_o[NUM_CNT-1:0] = ena_i;
        if (addr_i == OFS_MASK)   data_o[NUM_CNT-1:0] = mask_i;
        if (addr_i == OFS_STATUS) data_o[NUM_CNT-1:0] = status_i;
        if (addr_i == OFS_IDENT)  data_o[31:0]        = VERSION_ID;
        for (int r = 0; r < NUM_SEL; r++) begin
            if (addr_i == 16'(OFS_SELECT + 4 * r)) begin
                for (int b = 0; b < CODES_PER_SEL; b++)
                    data_o[8*b +: 8] = codes_i[CODES_PER_SEL*r + b];
            end
        end
        for (int n = 0; n < NUM_CNT; n++) begin
            if ((addr_i[15:3] == 13'((OFS_SLOT + 8 * n) >> 3)) && (addr_i[1:0] == 2'b00)) begin
                if (wide_i)          data_o[CNT_W-1:0] = cnt_i[n];
                else if (!addr_i[2]) data_o[31:0]      = cnt_i[n][31:0];
                else                 data_o[HI_W-1:0]  = cnt_i[n][CNT_W-1:32];
            end
        end
    end

endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
    import evt_cnt_pkg::*;
#(
    parameter int          NUM_CNT    = 16,
    parameter int          CNT_W      = 48,
    parameter int          EVT_NUM    = 64,
    parameter logic [31:0] VERSION_ID = 32'h5A17_0300
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid_i,
    input  logic               bus_write_i,
    input  logic               bus_wide_i,
    input  logic [15:0]        bus_addr_i,
    input  logic [63:0]        bus_wdata_i,
    output logic [63:0]        bus_rdata_o,
    input  logic [EVT_NUM-1:0] evt_i,
    output logic               irq_o
);

    localparam int NUM_SEL = NUM_CNT / CODES_PER_SEL;
    localparam int HI_W    = CNT_W - 32;

    typedef struct packed {
        logic                            run;
        logic [NUM_CNT-1:0]              ena;
        logic [NUM_CNT-1:0]              mask;
        logic [NUM_CNT-1:0]              status;
        logic [NUM_CNT-1:0][CODE_W-1:0]  codes;
        logic [63:0]                     rdata;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_w;
    logic [NUM_CNT-1:0]            wrap_w;
    logic [NUM_CNT-1:0]            wr_lo_w, wr_hi_w;
    logic [31:0]                   lo_val_w;
    logic [HI_W-1:0]               hi_val_w;
    logic [NUM_CNT-1:0]            clr_bits;
    logic [63:0]                   rd_word;
    logic                          wr_req, rd_req;
    logic                          unused_wdata;

    assign unused_wdata = ^bus_wdata_i[63:CNT_W];

    always_comb begin
        st_d     = st_q;
        wr_req   = bus_valid_i && bus_write_i;
        rd_req   = bus_valid_i && !bus_write_i;
        wr_lo_w  = '0;
        wr_hi_w  = '0;
        lo_val_w = bus_wdata_i[31:0];
        hi_val_w = bus_wide_i ? bus_wdata_i[CNT_W-1:32] : bus_wdata_i[HI_W-1:0];
        clr_bits = '0;

        if (wr_req) begin
            if (bus_addr_i == OFS_RUN)    st_d.run  = bus_wdata_i[0];
            if (bus_addr_i == OFS_ENABLE) st_d.ena  = bus_wdata_i[NUM_CNT-1:0];
            if (bus_addr_i == OFS_MASK)   st_d.mask = bus_wdata_i[NUM_CNT-1:0];
            if (bus_addr_i == OFS_CLEAR)  clr_bits  = bus_wdata_i[NUM_CNT-1:0];
            for (int r = 0; r < NUM_SEL; r++) begin
                if (bus_addr_i == 16'(OFS_SELECT + 4 * r)) begin
                    for (int b = 0; b < CODES_PER_SEL; b++)
                        st_d.codes[CODES_PER_SEL*r + b] = bus_wdata_i[8*b +: 8];
                end
            end
            for (int n = 0; n < NUM_CNT; n++) begin
                if ((bus_addr_i[15:3] == 13'((OFS_SLOT + 8 * n) >> 3)) && (bus_addr_i[1:0] == 2'b00)) begin
                    if (bus_wide_i) begin
                        wr_lo_w[n] = 1'b1;
                        wr_hi_w[n] = 1'b1;
                    end else if (!bus_addr_i[2]) begin
                        wr_lo_w[n] = 1'b1;
                    end else begin
                        wr_hi_w[n] = 1'b1;
                    end
                end
            end
        end

        // A wrap in the same cycle as a clear keeps the bit set.
        st_d.status = (st_q.status & ~clr_bits) | wrap_w;

        if (rd_req) st_d.rdata = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.run    <= 1'b0;
            st_q.ena    <= '0;
            st_q.mask   <= '1;
            st_q.status <= '0;
            st_q.codes  <= '1;
            st_q.rdata  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
        evt_cnt_lane #(
            .CNT_W   (CNT_W),
            .EVT_NUM (EVT_NUM)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (st_q.run && st_q.ena[g]),
            .code_i   (st_q.codes[g]),
            .evt_i    (evt_i),
            .wr_lo_i  (wr_lo_w[g]),
            .wr_hi_i  (wr_hi_w[g]),
            .lo_val_i (lo_val_w),
            .hi_val_i (hi_val_w),
            .cnt_o    (cnt_w[g]),
            .wrap_o   (wrap_w[g])
        );
    end

    evt_cnt_rdmux #(
        .NUM_CNT    (NUM_CNT),
        .CNT_W      (CNT_W),
        .VERSION_ID (VERSION_ID)
    ) u_rdmux (
        .addr_i   (bus_addr_i),
        .wide_i   (bus_wide_i),
        .run_i    (st_q.run),
        .ena_i    (st_q.ena),
        .mask_i   (st_q.mask),
        .status_i (st_q.status),
        .codes_i  (st_q.codes),
        .cnt_i    (cnt_w),
        .data_o   (rd_word)
    );

    assign bus_rdata_o = st_q.rdata;
    assign irq_o       = |(st_q.status & ~st_q.mask);

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && (bus_addr_i == OFS_CLEAR)) |=>
            ((st_q.status & $past(st_q.status)) == $past(st_q.status))); // R9
    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap_w) |=> ((st_q.status & $past(wrap_w)) == $past(wrap_w))); // R8
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.mask) |-> !irq_o); // R10
    AST_SLOT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (bus_addr_i >= OFS_SLOT)) |=> (bus_rdata_o[63:CNT_W] == '0)); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata_o)); // R12

endmodule

// File: tb/evt_cnt_bank_test.sv
`timescale 1ns/1ps
module evt_cnt_bank_test;

    localparam logic [31:0] VID = 32'h5A17_0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [63:0] evt = '0;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    evt_cnt_bank #(.VERSION_ID(VID)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid_i (bus_valid),
        .bus_write_i (bus_write),
        .bus_wide_i  (bus_wide),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .evt_i       (evt),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // All bus tasks are entered at a falling edge and return at the next one.
    task automatic bus_wr(input logic [15:0] a, input logic [63:0] d, input logic wide);
        bus_valid = 1'b1; bus_write = 1'b1; bus_wide = wide; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic wide, output logic [63:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_wide = wide; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0; bus_wide = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input int bit_idx, input int cycles);
        evt[bit_idx] = 1'b1;
        repeat (cycles) @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset;
        logic [63:0] v;
        bus_rd(16'h1E00, 1'b0, v); check("R1 run", v, 64'h0);
        bus_rd(16'h1E04, 1'b0, v); check("R1 enable", v, 64'h0);
        bus_rd(16'h0804, 1'b0, v); check("R1 mask", v, 64'hFFFF);
        bus_rd(16'h0808, 1'b0, v); check("R1 status", v, 64'h0);
        bus_rd(16'h1E8C, 1'b0, v); check("R1 select3", v, 64'hFFFF_FFFF);
        bus_rd(16'h1F78, 1'b1, v); check("R1 counter15", v, 64'h0);
        check("R1 irq", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_count;
        logic [63:0] v;
        bus_wr(16'h1E80, 64'hFF50_FF03, 1'b0);
        bus_wr(16'h1E04, 64'h1, 1'b0);
        bus_wr(16'h1E00, 64'h1, 1'b0);
        pulse(3, 5);
        bus_rd(16'h1F00, 1'b1, v); check("R2 five events", v, 64'd5);
    endtask

    task automatic t_gating;
        logic [63:0] v;
        bus_wr(16'h1E00, 64'h0, 1'b0);
        pulse(3, 4);
        bus_rd(16'h1F00, 1'b1, v); check("R4 run off holds", v, 64'd5);
        bus_wr(16'h1E00, 64'h1, 1'b0);
        bus_wr(16'h1E04, 64'h2, 1'b0);
        pulse(3, 4);
        bus_rd(16'h1F00, 1'b1, v); check("R5 own enable off holds", v, 64'd5);
    endtask

    task automatic t_codes;
        logic [63:0] v;
        bus_wr(16'h1E04, 64'hFFFF, 1'b0);
        evt = '1;
        repeat (3) @(negedge clk);
        evt = '0;
        bus_rd(16'h1F00, 1'b1, v); check("R2 all events", v, 64'd8);
        bus_rd(16'h1F08, 1'b1, v); check("R3 code FF", v, 64'd0);
        bus_rd(16'h1F10, 1'b1, v); check("R3 code 0x50 out of range", v, 64'd0);
        bus_rd(16'h1F78, 1'b1, v); check("R3 counter15 FF", v, 64'd0);
    endtask

    task automatic t_lanes;
        logic [63:0] v;
        bus_wr(16'h1E84, 64'hFFFF_07FF, 1'b0);
        bus_wr(16'h1E04, 64'h0070, 1'b0);
        pulse(7, 3);
        bus_rd(16'h1F28, 1'b1, v); check("R6 counter5 lane1", v, 64'd3);
        bus_rd(16'h1F20, 1'b1, v); check("R6 counter4 idle", v, 64'd0);
        bus_rd(16'h1F30, 1'b1, v); check("R6 counter6 idle", v, 64'd0);
        bus_rd(16'h1E84, 1'b0, v); check("R6 select1 readback", v, 64'hFFFF_07FF);
    endtask

    task automatic t_preload;
        logic [63:0] v;
        bus_wr(16'h1E04, 64'h0, 1'b0);
        bus_wr(16'h1F10, 64'hABCD_0000_0000_0012, 1'b1);
        bus_rd(16'h1F10, 1'b1, v); check("R7 wide preload", v, 64'h12);
        bus_wr(16'h1F14, 64'hFFFF_0007, 1'b0);
        bus_rd(16'h1F14, 1'b0, v); check("R7 high half", v, 64'h7);
        bus_wr(16'h1F10, 64'h89AB_CDEF, 1'b0);
        bus_rd(16'h1F10, 1'b1, v); check("R7 low half", v, 64'h0007_89AB_CDEF);
    endtask

    task automatic t_wrap;
        logic [63:0] v;
        bus_wr(16'h1E80, 64'hFF50_0303, 1'b0);
        bus_wr(16'h1E04, 64'h2, 1'b0);
        bus_wr(16'h1F08, 64'h0000_FFFF_FFFF_FFFE, 1'b1);
        pulse(3, 2);
        bus_rd(16'h1F08, 1'b1, v); check("R8 wrapped to zero", v, 64'h0);
        bus_rd(16'h0808, 1'b0, v); check("R8 status set", v, 64'h2);
        check("R10 masked irq low", {63'h0, irq}, 64'h0);
        bus_wr(16'h0804, 64'hFFFD, 1'b0);
        check("R10 unmasked irq high", {63'h0, irq}, 64'h1);
        bus_wr(16'h080C, 64'h0, 1'b0);
        bus_rd(16'h0808, 1'b0, v); check("R9 write zero no effect", v, 64'h2);
        bus_wr(16'h080C, 64'h2, 1'b0);
        bus_rd(16'h0808, 1'b0, v); check("R9 write one clears", v, 64'h0);
        check("R10 irq drops", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_race;
        logic [63:0] v;
        bus_wr(16'h1F08, 64'h0000_FFFF_FFFF_FFFF, 1'b1);
        evt[3] = 1'b1;
        bus_wr(16'h080C, 64'h2, 1'b0);
        evt = '0;
        bus_rd(16'h0808, 1'b0, v); check("R9 wrap beats clear", v, 64'h2);
        bus_rd(16'h1F08, 1'b1, v); check("R8 race counter zero", v, 64'h0);
        check("R10 irq after race", {63'h0, irq}, 64'h1);
    endtask

    task automatic t_misc;
        logic [63:0] v;
        bus_rd(16'h0100, 1'b0, v); check("R11 unmapped low", v, 64'h0);
        bus_rd(16'h1E90, 1'b0, v); check("R11 unmapped select gap", v, 64'h0);
        bus_rd(16'h1CF0, 1'b0, v); check("R11 identifier", v, {32'h0, VID});
        bus_wr(16'h0804, 64'hFFFF, 1'b0);
        check("R12 rdata held across write", bus_rdata, {32'h0, VID});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_count;
        t_gating;
        t_codes;
        t_lanes;
        t_preload;
        t_wrap;
        t_race;
        t_misc;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule